// File: doc/BRIEF.md
# Handshake-Paced Byte Transfer Engine

This block is the device end of a byte link to a host. Two host-driven control lines and one device-driven line are active low and sit in an 8-bit port register. The host-owned lines are transfer-in-progress on bit 5 and acknowledge on bit 4. The device-owned request line is on bit 3. A shift data register holds the byte in flight. Bit 4 of an auxiliary control register sets the direction: when it is set the host sends, and when it is clear the device sends.

Byte steps are paced by the host, not by a free-running counter. Each write to the port register or the auxiliary register re-evaluates the handshake against the previous port value. In the host-to-device direction, each edge on a handshake line stores the data register into a 16-entry receive buffer. When transfer-in-progress is raised, the finished packet is announced to a consumer with a one-cycle pulse and a byte count, and the consumer reads the bytes by address. In the device-to-host direction, each edge loads the next byte of a response packet of up to 128 bytes. Between transfers, request follows acknowledge. A shift-complete flag marks every step.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset, port_o is 8'hFF (request high), shift_flag_o is 0, sr_o is 0 and pkt_done_o is 0.
- R2: With auxiliary bit 4 set and port bit 5 low after the write, any change of port bits 4 or 5 from the previous port value stores sr_o into the next receive slot and sets shift_flag_o.
- R3: Once 16 bytes are held, further host-to-device steps store nothing and leave shift_flag_o unchanged; a packet never reports more than 16 bytes.
- R4: A write that raises port bit 5 from low always sets shift_flag_o. If at least one byte was received, pkt_done_o pulses for exactly one cycle with pkt_len_o equal to the count, and the count restarts at zero. The bytes can be read at rx_raddr_i.
- R5: With auxiliary bit 4 clear and port bit 5 low, any change of port bits 4 or 5 loads the next response byte into sr_o and sets shift_flag_o. After the last byte, request (port_o bit 3) goes high, and further steps leave sr_o unchanged.
- R6: With port bit 5 high both before and after a write, a change of acknowledge (bit 4) copies its new value onto request and sets shift_flag_o.
- R7: On an idle re-evaluation (bit 5 high, no acknowledge toggle), request is driven low whenever response bytes remain unsent.
- R8: rsp_load_i restarts the send index at zero with length rsp_len_i and sets shift_flag_o. If port bit 5 is high and the length is non-zero, it drives request low.
- R9: flag_clr_i clears shift_flag_o unless a set occurs in the same cycle.
- R10: A port or auxiliary write in the same cycle as rsp_load_i is dropped. An auxiliary write with no handshake change raises no flag.
- R11: sr_we_i writes sr_o; a response byte load in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_we_i | input | 1 | Port register write strobe |
| port_wdata_i | input | 8 | Port write data (bit 5 transfer-in-progress, bit 4 acknowledge) |
| port_o | output | 8 | Port register, bit 3 is device request |
| aux_we_i | input | 1 | Auxiliary register write strobe |
| aux_wdata_i | input | 8 | Auxiliary write data, bit 4 = host sends |
| sr_we_i | input | 1 | Data register write strobe |
| sr_wdata_i | input | 8 | Data register write value |
| sr_o | output | 8 | Data register |
| flag_clr_i | input | 1 | Clear shift-complete flag |
| shift_flag_o | output | 1 | Shift-complete flag |
| rsp_we_i | input | 1 | Send buffer write strobe |
| rsp_waddr_i | input | 7 | Send buffer write address |
| rsp_wdata_i | input | 8 | Send buffer write data |
| rsp_load_i | input | 1 | Start a new response packet |
| rsp_len_i | input | 8 | Response packet length |
| rx_raddr_i | input | 4 | Receive buffer read address |
| rx_rdata_o | output | 8 | Receive buffer read data |
| pkt_done_o | output | 1 | One-cycle packet-complete pulse |
| pkt_len_o | output | 5 | Byte count of completed packet |

## Verification
On every cycle the assertions check that packet-done pulses last one cycle, follow a rise of transfer-in-progress and carry a legal count. They also check that the flag holds until it is cleared, that a response load sets the flag and freezes the port, and that request changes only after a register write or a load. The bench scenarios are needed for the byte order in both directions, the overflow drop, the point where request goes high after the last byte, and the idle mirroring of acknowledge.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;
  localparam int unsigned REQ_BIT = 3;
  localparam int unsigned ACK_BIT = 4;
  localparam int unsigned TIP_BIT = 5;
  localparam int unsigned DIR_BIT = 4;

  typedef struct packed {
    logic rx_push;
    logic tx_pop;
    logic flag_set;
    logic pkt_done;
    logic req_we;
    logic req_val;
  } hs_act_t;
endpackage

// File: rtl/hs_rx_buf.sv
module hs_rx_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          clr_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign cnt_o   = cnt_q;
  assign rdata_o = mem_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[cnt_q[AW-1:0]] <= data_i;
  end
endmodule

// File: rtl/hs_tx_buf.sv
module hs_tx_buf #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          pop_i,
  output logic [DW-1:0] byte_o,
  output logic          rem_o,
  output logic          last_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] idx_q, len_q;
  logic [CW:0]   idx_nxt;

  assign idx_nxt = {1'b0, idx_q} + {{CW{1'b0}}, 1'b1};
  assign rem_o   = idx_q < len_q;
  assign last_o  = idx_nxt >= {1'b0, len_q};
  assign byte_o  = mem_q[idx_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      idx_q <= '0;
      len_q <= len_i;
    end else if (pop_i && rem_o) begin
      idx_q <= idx_nxt[CW-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_xfer_pkg::*;
(
  input  logic    ev_i,
  input  logic    dir_host_i,
  input  logic    tip_i,
  input  logic    ack_i,
  input  logic    tip_prev_i,
  input  logic    ack_prev_i,
  input  logic    rx_full_i,
  input  logic    rx_nz_i,
  input  logic    tx_rem_i,
  input  logic    tx_last_i,
  output hs_act_t act_o
);
  logic chg;
  assign chg = (tip_i != tip_prev_i) || (ack_i != ack_prev_i);

  always_comb begin
    act_o = '0;
    if (ev_i) begin
      if (!tip_i) begin
        if (dir_host_i) begin
          if (chg && !rx_full_i) begin
            act_o.rx_push  = 1'b1;
            act_o.flag_set = 1'b1;
          end
        end else if (chg && tx_rem_i) begin
          act_o.tx_pop   = 1'b1;
          act_o.flag_set = 1'b1;
          if (tx_last_i) begin
            act_o.req_we  = 1'b1;
            act_o.req_val = 1'b1;
          end
        end
      end else if (tip_prev_i && (ack_i != ack_prev_i)) begin
        // idle sync: request mirrors acknowledge
        act_o.req_we   = 1'b1;
        act_o.req_val  = ack_i;
        act_o.flag_set = 1'b1;
      end else begin
        if (!tip_prev_i) begin
          act_o.flag_set = 1'b1;
          act_o.pkt_done = rx_nz_i;
        end
        if (tx_rem_i) begin
          act_o.req_we  = 1'b1;
          act_o.req_val = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/hs_xfer_engine.sv
module hs_xfer_engine
  import hs_xfer_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned TX_DEPTH = 128,
  parameter int unsigned DW       = 8,
  localparam int unsigned RX_AW   = $clog2(RX_DEPTH),
  localparam int unsigned RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int unsigned TX_AW   = $clog2(TX_DEPTH),
  localparam int unsigned TX_CW   = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_we_i,
  input  logic [7:0]       port_wdata_i,
  output logic [7:0]       port_o,
  input  logic             aux_we_i,
  input  logic [7:0]       aux_wdata_i,
  input  logic             sr_we_i,
  input  logic [DW-1:0]    sr_wdata_i,
  output logic [DW-1:0]    sr_o,
  input  logic             flag_clr_i,
  output logic             shift_flag_o,
  input  logic             rsp_we_i,
  input  logic [TX_AW-1:0] rsp_waddr_i,
  input  logic [DW-1:0]    rsp_wdata_i,
  input  logic             rsp_load_i,
  input  logic [TX_CW-1:0] rsp_len_i,
  input  logic [RX_AW-1:0] rx_raddr_i,
  output logic [DW-1:0]    rx_rdata_o,
  output logic             pkt_done_o,
  output logic [RX_CW-1:0] pkt_len_o
);
  logic [7:0]       port_q;
  logic             dir_q, req_q, flag_q, done_q;
  logic [DW-1:0]    sr_q;
  logic [RX_CW-1:0] len_q, rx_cnt;
  logic             rx_full, tx_rem, tx_last, ev, tip_new, ack_new, dir_new;
  logic [DW-1:0]    tx_byte;
  hs_act_t          act;

  assign ev      = (port_we_i || aux_we_i) && !rsp_load_i;
  assign tip_new = port_we_i ? port_wdata_i[TIP_BIT] : port_q[TIP_BIT];
  assign ack_new = port_we_i ? port_wdata_i[ACK_BIT] : port_q[ACK_BIT];
  assign dir_new = aux_we_i ? aux_wdata_i[DIR_BIT] : dir_q;

  hs_ctrl u_ctrl (
    .ev_i       (ev),
    .dir_host_i (dir_new),
    .tip_i      (tip_new),
    .ack_i      (ack_new),
    .tip_prev_i (port_q[TIP_BIT]),
    .ack_prev_i (port_q[ACK_BIT]),
    .rx_full_i  (rx_full),
    .rx_nz_i    (rx_cnt != '0),
    .tx_rem_i   (tx_rem),
    .tx_last_i  (tx_last),
    .act_o      (act)
  );

  hs_rx_buf #(.DEPTH(RX_DEPTH), .DW(DW)) u_rx (
    .clk_i, .rst_ni,
    .push_i  (act.rx_push),
    .data_i  (sr_q),
    .clr_i   (act.pkt_done),
    .raddr_i (rx_raddr_i),
    .rdata_o (rx_rdata_o),
    .cnt_o   (rx_cnt),
    .full_o  (rx_full)
  );

  hs_tx_buf #(.DEPTH(TX_DEPTH), .DW(DW)) u_tx (
    .clk_i, .rst_ni,
    .we_i    (rsp_we_i),
    .waddr_i (rsp_waddr_i),
    .wdata_i (rsp_wdata_i),
    .load_i  (rsp_load_i),
    .len_i   (rsp_len_i),
    .pop_i   (act.tx_pop),
    .byte_o  (tx_byte),
    .rem_o   (tx_rem),
    .last_o  (tx_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q <= 8'hFF;
      dir_q  <= 1'b0;
      req_q  <= 1'b1;
      flag_q <= 1'b0;
      sr_q   <= '0;
      done_q <= 1'b0;
      len_q  <= '0;
    end else begin
      if (port_we_i && !rsp_load_i) port_q <= port_wdata_i;
      if (aux_we_i && !rsp_load_i)  dir_q  <= aux_wdata_i[DIR_BIT];
      if (rsp_load_i) begin
        if (port_q[TIP_BIT] && rsp_len_i != '0) req_q <= 1'b0;
      end else if (act.req_we) begin
        req_q <= act.req_val;
      end
      if (act.flag_set || rsp_load_i) flag_q <= 1'b1;
      else if (flag_clr_i)            flag_q <= 1'b0;
      if (act.tx_pop)   sr_q <= tx_byte;
      else if (sr_we_i) sr_q <= sr_wdata_i;
      done_q <= act.pkt_done;
      if (act.pkt_done) len_q <= rx_cnt;
    end
  end

  always_comb begin
    port_o          = port_q;
    port_o[REQ_BIT] = req_q;
  end

  assign sr_o         = sr_q;
  assign shift_flag_o = flag_q;
  assign pkt_done_o   = done_q;
  assign pkt_len_o    = len_q;
endmodule

// File: rtl/hs_xfer_checks.sv
module hs_xfer_checks
  import hs_xfer_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 16,
  localparam int unsigned RX_CW   = $clog2(RX_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             port_we_i,
  input logic             aux_we_i,
  input logic             rsp_load_i,
  input logic             flag_clr_i,
  input logic [7:0]       port_o,
  input logic             shift_flag_o,
  input logic             pkt_done_o,
  input logic [RX_CW-1:0] pkt_len_o
);
  p_flag_on_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_load_i |=> shift_flag_o);

  p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_flag_o && !flag_clr_i |=> shift_flag_o);

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |=> !pkt_done_o);

  p_done_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> port_o[TIP_BIT] && !$past(port_o[TIP_BIT]));

  p_done_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> (pkt_len_o != '0) && (pkt_len_o <= RX_CW'(RX_DEPTH)));

  p_req_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_o[REQ_BIT]) |-> $past(port_we_i || aux_we_i || rsp_load_i));

  p_port_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_load_i |=> $stable(port_o[TIP_BIT]));
endmodule

bind hs_xfer_engine hs_xfer_checks #(.RX_DEPTH(RX_DEPTH)) u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .port_we_i    (port_we_i),
  .aux_we_i     (aux_we_i),
  .rsp_load_i   (rsp_load_i),
  .flag_clr_i   (flag_clr_i),
  .port_o       (port_o),
  .shift_flag_o (shift_flag_o),
  .pkt_done_o   (pkt_done_o),
  .pkt_len_o    (pkt_len_o)
);

// File: tb/tb_hs_xfer_engine.sv
`timescale 1ns/100ps
module tb_hs_xfer_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 0, rst_ni = 0;
  logic       port_we_i = 0, aux_we_i = 0, sr_we_i = 0, flag_clr_i = 0;
  logic       rsp_we_i = 0, rsp_load_i = 0;
  logic [7:0] port_wdata_i = 8'hFF, aux_wdata_i = 0, sr_wdata_i = 0, rsp_wdata_i = 0;
  logic [6:0] rsp_waddr_i = 0;
  logic [7:0] rsp_len_i = 0;
  logic [3:0] rx_raddr_i = 0;
  logic [7:0] port_o, sr_o, rx_rdata_o;
  logic       shift_flag_o, pkt_done_o;
  logic [4:0] pkt_len_o;

  int n_chk = 0, n_fail = 0;
  int exp_len_q[$];
  logic [7:0] exp_byte_q[$];

  hs_xfer_engine dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pv(logic tip, logic ack);
    return {2'b11, tip, ack, 4'b1111};
  endfunction

  task automatic wr_port(logic tip, logic ack);
    @(negedge clk_i); port_we_i = 1; port_wdata_i = pv(tip, ack);
    @(negedge clk_i); port_we_i = 0;
  endtask
  task automatic wr_aux(logic [7:0] v);
    @(negedge clk_i); aux_we_i = 1; aux_wdata_i = v;
    @(negedge clk_i); aux_we_i = 0;
  endtask
  task automatic wr_sr(logic [7:0] v);
    @(negedge clk_i); sr_we_i = 1; sr_wdata_i = v;
    @(negedge clk_i); sr_we_i = 0;
  endtask
  task automatic clr_flag();
    @(negedge clk_i); flag_clr_i = 1;
    @(negedge clk_i); flag_clr_i = 0;
  endtask
  task automatic wr_rsp(logic [6:0] a, logic [7:0] d);
    @(negedge clk_i); rsp_we_i = 1; rsp_waddr_i = a; rsp_wdata_i = d;
    @(negedge clk_i); rsp_we_i = 0;
  endtask
  task automatic load_rsp(logic [7:0] len);
    @(negedge clk_i); rsp_load_i = 1; rsp_len_i = len;
    @(negedge clk_i); rsp_load_i = 0;
  endtask
  task automatic expect_pkt(logic [7:0] first, int len);
    exp_len_q.push_back(len);
    for (int i = 0; i < len; i++) exp_byte_q.push_back(first + 8'(i));
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (pkt_done_o) begin
        if (exp_len_q.size() == 0) begin
          chk("R4 unexpected packet", 1, 0);
        end else begin
          int len;
          len = exp_len_q.pop_front();
          chk("R4 packet length", 32'(pkt_len_o), 32'(len));
          for (int i = 0; i < len; i++) begin
            rx_raddr_i = 4'(i);
            #0.2;
            chk("R2 packet byte", 32'(rx_rdata_o), 32'(exp_byte_q.pop_front()));
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk_i); rst_ni = 1;
    // R1 reset state
    chk("R1 port", 32'(port_o), 32'hFF);
    chk("R1 flag", 32'(shift_flag_o), 0);
    chk("R1 sr", 32'(sr_o), 0);
    chk("R1 done", 32'(pkt_done_o), 0);

    // host to device, 3 bytes
    wr_aux(8'h10);
    chk("R10 aux write no flag", 32'(shift_flag_o), 0);
    wr_sr(8'hA0);
    chk("R11 sr write", 32'(sr_o), 32'hA0);
    wr_port(0, 1);
    chk("R2 flag after step", 32'(shift_flag_o), 1);
    clr_flag();
    chk("R9 flag cleared", 32'(shift_flag_o), 0);
    wr_port(0, 1);
    chk("R10 no change no flag", 32'(shift_flag_o), 0);
    wr_sr(8'hA1); wr_port(0, 0);
    wr_sr(8'hA2); wr_port(0, 1);
    chk("R2 flag after ack toggle", 32'(shift_flag_o), 1);
    clr_flag();
    expect_pkt(8'hA0, 3);
    wr_port(1, 1);
    chk("R4 flag on rise", 32'(shift_flag_o), 1);
    @(negedge clk_i);
    chk("R4 pulse ended", 32'(pkt_done_o), 0);

    // overflow: 18 steps, 16 kept
    for (int i = 0; i < 18; i++) begin
      wr_sr(8'h40 + 8'(i));
      if (i == 16) clr_flag();
      wr_port(0, (i % 2) == 0);
      if (i == 16) chk("R3 no flag when full", 32'(shift_flag_o), 0);
    end
    expect_pkt(8'h40, 16);
    wr_port(1, 0);
    @(negedge clk_i);

    // device to host
    wr_aux(8'h00);
    wr_port(1, 1);
    wr_rsp(0, 8'h5A); wr_rsp(1, 8'h5B); wr_rsp(2, 8'h5C);
    clr_flag();
    load_rsp(3);
    chk("R8 request low on load", 32'(port_o[3]), 0);
    chk("R8 flag on load", 32'(shift_flag_o), 1);
    clr_flag();
    wr_port(0, 1);
    chk("R5 first byte", 32'(sr_o), 32'h5A);
    chk("R5 flag", 32'(shift_flag_o), 1);
    wr_port(0, 0);
    chk("R5 second byte", 32'(sr_o), 32'h5B);
    chk("R5 request still low", 32'(port_o[3]), 0);
    wr_port(0, 1);
    chk("R5 last byte", 32'(sr_o), 32'h5C);
    chk("R5 request high after last", 32'(port_o[3]), 1);
    wr_port(0, 0);
    chk("R5 no byte past end", 32'(sr_o), 32'h5C);
    clr_flag();
    wr_port(1, 0);
    chk("R4 flag on empty rise", 32'(shift_flag_o), 1);
    chk("R7 request high when drained", 32'(port_o[3]), 1);

    // idle sync
    clr_flag();
    wr_port(1, 1);
    chk("R6 flag on ack toggle", 32'(shift_flag_o), 1);
    wr_port(1, 0);
    chk("R6 request follows ack low", 32'(port_o[3]), 0);
    wr_port(1, 1);
    chk("R6 request follows ack high", 32'(port_o[3]), 1);

    // remaining bytes signalled on idle
    wr_port(0, 1);
    wr_rsp(0, 8'h11); wr_rsp(1, 8'h22);
    load_rsp(2);
    chk("R8 no request while busy", 32'(port_o[3]), 1);
    wr_port(1, 1);
    chk("R7 request low with bytes left", 32'(port_o[3]), 0);

    // load and port write in the same cycle
    @(negedge clk_i);
    rsp_load_i = 1; rsp_len_i = 2; port_we_i = 1; port_wdata_i = pv(0, 1);
    @(negedge clk_i);
    rsp_load_i = 0; port_we_i = 0;
    chk("R10 port write dropped", 32'(port_o[5]), 1);

    // sr write collides with byte load
    @(negedge clk_i);
    sr_we_i = 1; sr_wdata_i = 8'hEE; port_we_i = 1; port_wdata_i = pv(0, 1);
    @(negedge clk_i);
    sr_we_i = 0; port_we_i = 0;
    chk("R11 byte load wins", 32'(sr_o), 32'h11);

    repeat (3) @(negedge clk_i);
    chk("R4 all packets seen", 32'(exp_len_q.size()), 0);
    finish_run();
  end
endmodule